// File: doc/BRIEF.md
# Bootstrap Pin Latch and Reset Sequencer

This block decides what happens when each kind of reset is released. It watches four reset request lines: power-on, full, plain (hard or soft) and local. For each request it decides whether the external bootstrap pins are copied into a 13-bit strap status word and whether a boot is started. The status word is split into three fields: a boot device code, a device-specific configuration field and a PLL selection. For the I2C and SPI boot devices the PLL selection field is read as an extension of the device configuration instead.

Software can write a small power-state register that holds a hibernation mode and a resume address. When a boot is due and the hibernation mode is nonzero, the block raises a resume pulse in place of the boot pulse. The resume address is presented on its own output. Local resets never start a boot. They only produce a core reset pulse.

Top module: `boot_strap_ctrl`

## Requirements
- R1: The strap status word is split into fields: bits [2:0] are the boot device code, bits [9:3] are the device configuration, and bits [12:10] are the PLL selection. Each field is presented on its own output, and the status word can be read in every cycle.
- R2: While the power-on request is high, the status word is all zeros. When the request is released, the pins are latched and a boot is started.
- R3: A full reset latches the bootstrap pins at its release and starts a boot.
- R4: A plain reset starts a boot. The status word keeps its previous value whatever the pins show, and the status word changes only in the cycle that a boot or resume pulse marks.
- R5: A local reset gives a single-cycle core reset pulse. It gives no boot pulse, no resume pulse and no change to the status word.
- R6: The boot pulse is one cycle wide. It is high in the cycle after the clock edge at which all reset requests are first seen low. It is never high in the cycle after an edge at which any request is high.
- R7: All requests seen during one active period, whether they overlap or arrive in sequence, are merged. The highest class decides the action, in the order power-on, full, plain, local.
- R8: Device codes are 0 sleep/parallel NOR, 1 serial RapidIO, 2 Ethernet with the accelerator on the core clock, 3 Ethernet with the accelerator on its own PLL, 4 PCIe, 5 I2C, 6 SPI and 7 chip-to-chip link. For codes 5 and 6, the bypass output is 1, the PLL selection output is 0 and the extended configuration output carries bits [12:10]. For all other codes, the bypass output is 0 and the extended configuration output is 0.
- R9: If the stored hibernation mode is nonzero when a boot would start, a one-cycle resume pulse is given instead of the boot pulse. The resume address output shows the address that software stored.
- R10: A power-on reset or a full reset clears the hibernation mode and the resume address. The boot that follows is therefore a normal boot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request, active high |
| full_req | input | 1 | Full reset request, active high |
| plain_req | input | 1 | Plain (hard/soft) reset request, active high |
| local_req | input | 1 | Core-only reset request, active high |
| strap_pins | input | 13 | External bootstrap pins |
| pwr_we | input | 1 | Write strobe for the power-state register |
| pwr_mode | input | 2 | Hibernation mode to write |
| pwr_addr | input | 32 | Resume address to write |
| status_word | output | 13 | Latched strap status word |
| boot_dev | output | 3 | Boot device code |
| dev_cfg | output | 7 | Device configuration field |
| pll_sel | output | 3 | PLL selection (0 when bypassed) |
| ext_cfg | output | 3 | Extended configuration (I2C/SPI only) |
| pll_bypass | output | 1 | PLL bypassed for the selected device |
| boot_start | output | 1 | One-cycle boot start pulse |
| core_rst | output | 1 | One-cycle core-only reset pulse |
| hib_resume | output | 1 | One-cycle hibernation resume pulse |
| resume_addr | output | 32 | Stored resume address |

## Verification
The bench builds the block with its default widths: a 3-bit device field, a 7-bit configuration field, a 3-bit PLL field, a 2-bit hibernation mode and a 32-bit address. At these widths every device code can be driven, so both sides of the bypass decode are reached. Its stimulus covers each reset class on its own, overlapping and sequential mixtures of classes, and pin changes under a plain reset. It also covers a stored hibernation mode that is then cleared by a full reset.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    // Reset classes, ordered so that a larger value wins.
    typedef enum logic [2:0] {
        RC_NONE  = 3'd0,
        RC_LOCAL = 3'd1,
        RC_PLAIN = 3'd2,
        RC_FULL  = 3'd3,
        RC_POR   = 3'd4
    } rst_cls_e;

    // Boot device codes carried in the low strap field.
    typedef enum logic [2:0] {
        BD_SLEEP_NOR   = 3'd0,
        BD_SRIO        = 3'd1,
        BD_ETH_CORECLK = 3'd2,
        BD_ETH_OWNPLL  = 3'd3,
        BD_PCIE        = 3'd4,
        BD_I2C         = 3'd5,
        BD_SPI         = 3'd6,
        BD_CHIPLINK    = 3'd7
    } boot_dev_e;

endpackage

// File: rtl/bsc_reset_prio.sv
module bsc_reset_prio
    import bsc_pkg::*;
(
    input  logic     req_por,
    input  logic     req_full,
    input  logic     req_plain,
    input  logic     req_local,
    output rst_cls_e cls
);
    always_comb begin
        if (req_por)        cls = RC_POR;
        else if (req_full)  cls = RC_FULL;
        else if (req_plain) cls = RC_PLAIN;
        else if (req_local) cls = RC_LOCAL;
        else                cls = RC_NONE;
    end
endmodule

// File: rtl/bsc_field_decode.sv
module bsc_field_decode
    import bsc_pkg::*;
#(
    parameter int DEV_W = 3,
    parameter int CFG_W = 7,
    parameter int PLL_W = 3
) (
    input  logic [DEV_W+CFG_W+PLL_W-1:0] word,
    output logic [DEV_W-1:0]             dev,
    output logic [CFG_W-1:0]             cfg,
    output logic [PLL_W-1:0]             pll_sel,
    output logic [PLL_W-1:0]             ext_cfg,
    output logic                         bypass
);
    localparam int CFG_LO = DEV_W;
    localparam int PLL_LO = DEV_W + CFG_W;

    logic [PLL_W-1:0] upper;

    always_comb begin
        dev    = word[DEV_W-1:0];
        cfg    = word[CFG_LO +: CFG_W];
        upper  = word[PLL_LO +: PLL_W];
        bypass = (dev == DEV_W'(BD_I2C)) || (dev == DEV_W'(BD_SPI));
        if (bypass) begin
            pll_sel = '0;
            ext_cfg = upper;
        end else begin
            pll_sel = upper;
            ext_cfg = '0;
        end
    end
endmodule

// File: rtl/boot_strap_ctrl.sv
module boot_strap_ctrl
    import bsc_pkg::*;
#(
    parameter int DEV_W  = 3,
    parameter int CFG_W  = 7,
    parameter int PLL_W  = 3,
    parameter int HIB_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic                         clk,
    input  logic                         por_req,
    input  logic                         full_req,
    input  logic                         plain_req,
    input  logic                         local_req,
    input  logic [DEV_W+CFG_W+PLL_W-1:0] strap_pins,
    input  logic                         pwr_we,
    input  logic [HIB_W-1:0]             pwr_mode,
    input  logic [ADDR_W-1:0]            pwr_addr,
    output logic [DEV_W+CFG_W+PLL_W-1:0] status_word,
    output logic [DEV_W-1:0]             boot_dev,
    output logic [CFG_W-1:0]             dev_cfg,
    output logic [PLL_W-1:0]             pll_sel,
    output logic [PLL_W-1:0]             ext_cfg,
    output logic                         pll_bypass,
    output logic                         boot_start,
    output logic                         core_rst,
    output logic                         hib_resume,
    output logic [ADDR_W-1:0]            resume_addr
);
    localparam int STAT_W = DEV_W + CFG_W + PLL_W;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        rst_cls_e          pend;
        logic              boot;
        logic              core;
        logic              hib;
        logic [HIB_W-1:0]  hmode;
        logic [ADDR_W-1:0] haddr;
    } state_t;

    state_t   st_d, st_q;
    rst_cls_e cls;

    bsc_reset_prio u_prio (
        .req_por   (por_req),
        .req_full  (full_req),
        .req_plain (plain_req),
        .req_local (local_req),
        .cls       (cls)
    );

    always_comb begin
        st_d      = st_q;
        st_d.boot = 1'b0;
        st_d.core = 1'b0;
        st_d.hib  = 1'b0;
        if (por_req) begin
            // Power-on: clear everything and remember the class.
            st_d.pend  = RC_POR;
            st_d.stat  = '0;
            st_d.hmode = '0;
            st_d.haddr = '0;
        end else if (cls != RC_NONE) begin
            // Active period: merge the highest class seen so far.
            if (cls > st_q.pend) st_d.pend = cls;
            if (full_req) begin
                st_d.hmode = '0;
                st_d.haddr = '0;
            end else if (pwr_we) begin
                st_d.hmode = pwr_mode;
                st_d.haddr = pwr_addr;
            end
        end else begin
            // Release: act on the merged class exactly once.
            if (st_q.pend != RC_NONE) begin
                if (st_q.pend >= RC_FULL) st_d.stat = strap_pins;
                if (st_q.pend >= RC_PLAIN) begin
                    if (st_q.hmode != '0) st_d.hib  = 1'b1;
                    else                  st_d.boot = 1'b1;
                end
                if (st_q.pend == RC_LOCAL) st_d.core = 1'b1;
                st_d.pend = RC_NONE;
            end
            if (pwr_we) begin
                st_d.hmode = pwr_mode;
                st_d.haddr = pwr_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    bsc_field_decode #(
        .DEV_W (DEV_W),
        .CFG_W (CFG_W),
        .PLL_W (PLL_W)
    ) u_dec (
        .word    (st_q.stat),
        .dev     (boot_dev),
        .cfg     (dev_cfg),
        .pll_sel (pll_sel),
        .ext_cfg (ext_cfg),
        .bypass  (pll_bypass)
    );

    assign status_word = st_q.stat;
    assign boot_start  = st_q.boot;
    assign core_rst    = st_q.core;
    assign hib_resume  = st_q.hib;
    assign resume_addr = st_q.haddr;

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
    parameter int DEV_W  = 3,
    parameter int CFG_W  = 7,
    parameter int PLL_W  = 3
) (
    input logic                         clk,
    input logic                         por_req,
    input logic                         full_req,
    input logic                         plain_req,
    input logic                         local_req,
    input logic [DEV_W+CFG_W+PLL_W-1:0] status_word,
    input logic [PLL_W-1:0]             pll_sel,
    input logic [PLL_W-1:0]             ext_cfg,
    input logic                         pll_bypass,
    input logic                         boot_start,
    input logic                         core_rst,
    input logic                         hib_resume
);
    logic any_req;
    assign any_req = por_req | full_req | plain_req | local_req;

    assert_boot_single_R6: assert property (@(posedge clk) disable iff (por_req)
        boot_start |=> !boot_start);

    assert_no_pulse_in_req_R6: assert property (@(posedge clk) disable iff (por_req)
        any_req |=> (!boot_start && !hib_resume && !core_rst));

    assert_status_only_at_boot_R4: assert property (@(posedge clk) disable iff (por_req)
        !$stable(status_word) |-> (boot_start || hib_resume));

    assert_local_core_only_R5: assert property (@(posedge clk) disable iff (por_req)
        core_rst |-> (!boot_start && !hib_resume));

    assert_resume_excl_R9: assert property (@(posedge clk) disable iff (por_req)
        hib_resume |-> !boot_start);

    assert_bypass_pll_zero_R8: assert property (@(posedge clk) disable iff (por_req)
        pll_bypass |-> (pll_sel == '0));

    assert_no_ext_cfg_R8: assert property (@(posedge clk) disable iff (por_req)
        !pll_bypass |-> (ext_cfg == '0));

endmodule

bind boot_strap_ctrl bsc_checker #(
    .DEV_W (DEV_W),
    .CFG_W (CFG_W),
    .PLL_W (PLL_W)
) chk_i (
    .clk         (clk),
    .por_req     (por_req),
    .full_req    (full_req),
    .plain_req   (plain_req),
    .local_req   (local_req),
    .status_word (status_word),
    .pll_sel     (pll_sel),
    .ext_cfg     (ext_cfg),
    .pll_bypass  (pll_bypass),
    .boot_start  (boot_start),
    .core_rst    (core_rst),
    .hib_resume  (hib_resume)
);

// File: tb/boot_strap_ctrl_tb_top.sv
module boot_strap_ctrl_tb_top;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        por_req, full_req, plain_req, local_req;
    logic [12:0] strap_pins;
    logic        pwr_we;
    logic [1:0]  pwr_mode;
    logic [31:0] pwr_addr;
    logic [12:0] status_word;
    logic [2:0]  boot_dev;
    logic [6:0]  dev_cfg;
    logic [2:0]  pll_sel, ext_cfg;
    logic        pll_bypass, boot_start, core_rst, hib_resume;
    logic [31:0] resume_addr;

    boot_strap_ctrl dut_i (
        .clk(clk), .por_req(por_req), .full_req(full_req), .plain_req(plain_req),
        .local_req(local_req), .strap_pins(strap_pins), .pwr_we(pwr_we),
        .pwr_mode(pwr_mode), .pwr_addr(pwr_addr), .status_word(status_word),
        .boot_dev(boot_dev), .dev_cfg(dev_cfg), .pll_sel(pll_sel), .ext_cfg(ext_cfg),
        .pll_bypass(pll_bypass), .boot_start(boot_start), .core_rst(core_rst),
        .hib_resume(hib_resume), .resume_addr(resume_addr)
    );

    int checks = 0;
    int errors = 0;
    int n_boot = 0, n_core = 0, n_hib = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit          m_valid = 0;
    int          m_pend  = 0;      // 0 none, 1 local, 2 plain, 3 full, 4 power-on
    logic [12:0] m_stat;
    bit          m_boot, m_core, m_hib;
    int          m_hmode;
    logic [31:0] m_haddr;

    always @(posedge clk) begin
        int c;
        c = por_req ? 4 : full_req ? 3 : plain_req ? 2 : local_req ? 1 : 0;
        m_boot = 0; m_core = 0; m_hib = 0;
        if (por_req) begin
            m_valid = 1; m_pend = 4; m_stat = '0; m_hmode = 0; m_haddr = '0;
        end else if (c != 0) begin
            if (c > m_pend) m_pend = c;
            if (full_req) begin m_hmode = 0; m_haddr = '0; end
            else if (pwr_we) begin m_hmode = pwr_mode; m_haddr = pwr_addr; end
        end else begin
            if (m_pend >= 3) m_stat = strap_pins;
            if (m_pend >= 2) begin
                if (m_hmode != 0) m_hib = 1; else m_boot = 1;
            end
            if (m_pend == 1) m_core = 1;
            m_pend = 0;
            if (pwr_we) begin m_hmode = pwr_mode; m_haddr = pwr_addr; end
        end
    end

    // Per-cycle comparison and pulse counting, away from the active edge
    always @(negedge clk) begin
        if (boot_start === 1'b1) n_boot++;
        if (core_rst === 1'b1)   n_core++;
        if (hib_resume === 1'b1) n_hib++;
        if (m_valid && !por_req) begin
            bit byp;
            byp = (m_stat[2:0] == 3'd5) || (m_stat[2:0] == 3'd6);
            chk(status_word === m_stat, "R3 model status", status_word, m_stat);
            chk(boot_start === m_boot, "R6 model boot pulse", boot_start, m_boot);
            chk(core_rst === m_core, "R5 model core pulse", core_rst, m_core);
            chk(hib_resume === m_hib, "R9 model resume pulse", hib_resume, m_hib);
            chk(resume_addr === m_haddr, "R9 model resume addr", resume_addr, m_haddr);
            chk(pll_bypass === byp, "R8 model bypass", pll_bypass, byp);
        end
    end

    // Drive one reset class mix, release, and check the pulses at exact cycles.
    task automatic do_reset(input bit p, input bit f, input bit pl, input bit lo, input int hold,
                            input bit eb, input bit ec, input bit eh, input string tag);
        int b0, c0, h0;
        @(negedge clk);
        por_req = p; full_req = f; plain_req = pl; local_req = lo;
        repeat (hold) @(negedge clk);
        por_req = 0; full_req = 0; plain_req = 0; local_req = 0;
        b0 = n_boot; c0 = n_core; h0 = n_hib;
        @(negedge clk);
        chk(boot_start === eb, {tag, " R6 boot pulse in cycle after release"}, boot_start, eb);
        chk(core_rst === ec, {tag, " R5 core pulse after release"}, core_rst, ec);
        chk(hib_resume === eh, {tag, " R9 resume pulse after release"}, hib_resume, eh);
        @(negedge clk);
        chk(boot_start === 1'b0, {tag, " R6 boot pulse one cycle wide"}, boot_start, 0);
        repeat (2) @(negedge clk);
        chk((n_boot - b0) == int'(eb), {tag, " R6 boot pulse count"}, n_boot - b0, eb);
        chk((n_core - c0) == int'(ec), {tag, " R5 core pulse count"}, n_core - c0, ec);
        chk((n_hib - h0) == int'(eh), {tag, " R9 resume pulse count"}, n_hib - h0, eh);
    endtask

    localparam logic [12:0] P1 = {3'd2, 7'h15, 3'd1};
    localparam logic [12:0] P2 = {3'd6, 7'h2A, 3'd5};
    localparam logic [12:0] P3 = {3'd7, 7'h7F, 3'd6};
    localparam logic [12:0] P4 = {3'd4, 7'h33, 3'd2};
    localparam logic [12:0] P5 = {3'd5, 7'h53, 3'd3};
    localparam logic [12:0] P6 = {3'd1, 7'h01, 3'd6};

    initial begin
        por_req = 1; full_req = 0; plain_req = 0; local_req = 0;
        strap_pins = P1; pwr_we = 0; pwr_mode = 0; pwr_addr = '0;
        repeat (5) @(negedge clk);
        chk(status_word === 13'd0, "R2 status zero during power-on", status_word, 0);
        chk(boot_start === 1'b0, "R2 no boot during power-on", boot_start, 0);
        por_req = 0;
        @(negedge clk);
        chk(boot_start === 1'b1, "R2 boot after power-on release", boot_start, 1);
        repeat (2) @(negedge clk);
        chk(status_word === P1, "R2 pins latched on power-on", status_word, P1);
        chk(boot_dev === 3'd1 && dev_cfg === 7'h15 && pll_sel === 3'd2,
            "R1 fields of P1", {boot_dev, dev_cfg, pll_sel}, {3'd1, 7'h15, 3'd2});

        // Full reset onto an I2C strap
        strap_pins = P2;
        do_reset(0, 1, 0, 0, 3, 1, 0, 0, "full");
        chk(status_word === P2, "R3 full reset latches pins", status_word, P2);
        chk(pll_bypass === 1'b1 && pll_sel === 3'd0 && ext_cfg === 3'd6,
            "R8 I2C bypass decode", {pll_bypass, pll_sel, ext_cfg}, {1'b1, 3'd0, 3'd6});

        // Plain reset with different pins: ignored
        strap_pins = P3;
        do_reset(0, 0, 1, 0, 3, 1, 0, 0, "plain");
        chk(status_word === P2, "R4 plain reset keeps status", status_word, P2);

        // Local reset
        do_reset(0, 0, 0, 1, 2, 0, 1, 0, "local");
        chk(status_word === P2, "R5 local reset keeps status", status_word, P2);

        // Overlapping classes: full wins
        strap_pins = P4;
        do_reset(0, 1, 1, 1, 4, 1, 0, 0, "overlap");
        chk(status_word === P4, "R7 overlap full wins and latches", status_word, P4);
        chk(pll_bypass === 1'b0 && ext_cfg === 3'd0 && pll_sel === 3'd4,
            "R8 no bypass for Ethernet", {pll_bypass, ext_cfg, pll_sel}, {1'b0, 3'd0, 3'd4});

        // Sequential classes within one active period: local then plain
        begin
            int b0, c0;
            strap_pins = P5;
            @(negedge clk); local_req = 1;
            repeat (2) @(negedge clk); plain_req = 1;
            repeat (2) @(negedge clk); local_req = 0;
            repeat (2) @(negedge clk); plain_req = 0;
            b0 = n_boot; c0 = n_core;
            repeat (4) @(negedge clk);
            chk((n_boot - b0) == 1, "R7 sequential plain wins boot", n_boot - b0, 1);
            chk((n_core - c0) == 0, "R7 sequential no core pulse", n_core - c0, 0);
            chk(status_word === P4, "R7 sequential plain keeps status", status_word, P4);
        end

        // Field check on another strap via full reset
        do_reset(0, 1, 0, 0, 2, 1, 0, 0, "fields");
        chk(boot_dev === 3'd3 && dev_cfg === 7'h53 && pll_sel === 3'd5 && pll_bypass === 1'b0,
            "R1 fields of P5", {boot_dev, dev_cfg, pll_sel, pll_bypass}, {3'd3, 7'h53, 3'd5, 1'b0});

        // Hibernation resume after plain reset
        @(negedge clk); pwr_we = 1; pwr_mode = 2'd1; pwr_addr = 32'h1234_5678;
        @(negedge clk); pwr_we = 0;
        do_reset(0, 0, 1, 0, 3, 0, 0, 1, "hibernate");
        chk(resume_addr === 32'h1234_5678, "R9 resume address", resume_addr, 32'h1234_5678);

        // Full reset clears the hibernation state
        strap_pins = P6;
        do_reset(0, 1, 0, 0, 2, 1, 0, 0, "clear");
        chk(resume_addr === 32'h0, "R10 full reset clears resume address", resume_addr, 0);
        chk(pll_bypass === 1'b1 && ext_cfg === 3'd1, "R8 SPI bypass decode",
            {pll_bypass, ext_cfg}, {1'b1, 3'd1});

        // Power-on also clears it
        @(negedge clk); pwr_we = 1; pwr_mode = 2'd3; pwr_addr = 32'hCAFE_0000;
        @(negedge clk); pwr_we = 0;
        strap_pins = P1;
        do_reset(1, 0, 0, 0, 3, 1, 0, 0, "por2");
        chk(status_word === P1, "R2 second power-on latches", status_word, P1);
        chk(resume_addr === 32'h0, "R10 power-on clears resume address", resume_addr, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R6: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule